// File: doc/BRIEF.md
# Banked Indirect Extended-SRAM Access Port

This block gives a byte-wide register bus access to a large internal byte memory through a small window of registers. A bank bit in a main control register picks what the upper half of the register space (offsets 0x40 to 0x7F) shows.

With the bank bit clear, that half is 64 bytes of plain user RAM. With the bank bit set, it holds a few extended registers instead:
- an address low byte and an address high byte, which hold a pointer into the extended memory;
- a data port, which reads or writes the byte at that pointer;
- an extended control register, whose burst bit makes the pointer step forward by one after every data-port access.

The burst bit lets software stream through the memory without reloading the address. The memory size is a parameter of 2048, 4096 or 8192 bytes. The pointer holds only as many bits as that size needs. It wraps to zero past the last byte.

Reads are registered. The bus presents an offset with a read strobe, and the byte appears on the read-data output after the next rising clock edge. It then holds until the next read.

Top module: `nvport_top`

## Requirements
- R1: After reset the read-data output is 0x00, and the main control register, the extended control register and both address bytes all read back as 0x00.
- R2: Read data is registered. It takes its new value at the clock edge that samples the read strobe, and it holds its value in every cycle without a read strobe.
- R3: Offset 0x0A is the main control register, and it is readable and writable in both banks. Its bit 4 is the bank bit. With bit 4 clear, offsets 0x40 to 0x7F read and write 64 bytes of user RAM, indexed by offset bits 5:0.
- R4: With the bank bit set, these offsets are live: 0x50 is the address low byte (pointer bits 7:0), 0x51 is the address high byte (pointer bits above 7, in its low bits), 0x53 is the data port, and 0x4A is the extended control register.
- R5: When bit 5 of the extended control register is 1, every data-port read or write moves the pointer forward by one after the access. A read returns the byte at the pointer before the step.
- R6: When bit 5 of the extended control register is 0, data-port accesses leave the pointer unchanged.
- R7: When the pointer steps past the last byte of the memory, it wraps to zero.
- R8: Pointer bits at or above log2 of the memory size are not stored. Writing them has no effect, and they read back as 0 in the address high byte.
- R9: The address bytes read back the pointer's current value, including any burst steps.
- R10: With the bank bit clear, writes to 0x40 to 0x7F reach only user RAM. The extended registers and the pointer keep their values.
- R11: Offsets not mapped in the current bank read as 0x00. This covers 0x00, and, with the bank bit set, 0x52 and the 0x40 to 0x7F offsets that are not extended registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the current offset |
| rdEn | input | 1 | Read strobe for the current offset |
| regAddr | input | 7 | Register offset 0x00 to 0x7F |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
The bench builds the block with the smallest memory size, 2048 bytes. This gives an 11-bit pointer whose last byte, 0x7FF, takes only a few writes to reach, so the wrap to zero is checked directly. It also leaves five unused bits in the address high byte, where writing all ones shows that the unstored bits are dropped on readback and do not affect which byte is accessed. At this size the whole burst, bank-switch and user-RAM sequence fits in one short table of vectors.

// File: rtl/nvport_pkg.sv
package nvport_pkg;

  // where the registered read data comes from
  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_REG  = 2'd1,
    RD_USER = 2'd2,
    RD_EXT  = 2'd3
  } rdSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   extWr;
    logic   userWr;
    logic   rdEn;
    rdSrc_e rdSrc;
  } nvStrobe_t;

  localparam logic [6:0] OFS_MAIN_CTL = 7'h0A;
  localparam logic [6:0] OFS_EXT_CTL  = 7'h4A;
  localparam logic [6:0] OFS_PTR_LO   = 7'h50;
  localparam logic [6:0] OFS_PTR_HI   = 7'h51;
  localparam logic [6:0] OFS_DPORT    = 7'h53;
  localparam int         BANK_BIT     = 4;
  localparam int         BURST_BIT    = 5;

endpackage

// File: rtl/nvport_ctrl.sv
module nvport_ctrl
  import nvport_pkg::*;
#(
  parameter int EXT_BYTES = 2048,
  localparam int AW = $clog2(EXT_BYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [6:0]    regAddr,
  input  logic [7:0]    wdata,
  output nvStrobe_t     strb,
  output logic [AW-1:0] extAddr,
  output logic [7:0]    regVal
);

  localparam int HW = AW - 8;

  logic [7:0] mainCtl;
  logic [7:0] extCtl;
  logic       bankSel;
  logic       burstOn;
  logic       dpHit;
  logic       dpAccess;

  assign bankSel  = mainCtl[BANK_BIT];
  assign burstOn  = extCtl[BURST_BIT];
  assign dpHit    = bankSel && (regAddr == OFS_DPORT);
  assign dpAccess = dpHit && (wrEn || rdEn);

  // decode of the offset into read source, register value and write strobes
  always_comb begin
    strb.extWr  = 1'b0;
    strb.userWr = 1'b0;
    strb.rdEn   = rdEn;
    strb.rdSrc  = RD_ZERO;
    regVal      = 8'h00;
    if (regAddr == OFS_MAIN_CTL) begin
      strb.rdSrc = RD_REG;
      regVal     = mainCtl;
    end else if (regAddr[6] && !bankSel) begin
      strb.rdSrc  = RD_USER;
      strb.userWr = wrEn;
    end else if (bankSel) begin
      case (regAddr)
        OFS_EXT_CTL: begin strb.rdSrc = RD_REG; regVal = extCtl; end
        OFS_PTR_LO:  begin strb.rdSrc = RD_REG; regVal = extAddr[7:0]; end
        OFS_PTR_HI:  begin strb.rdSrc = RD_REG; regVal = 8'(extAddr[AW-1:8]); end
        OFS_DPORT:   begin strb.rdSrc = RD_EXT; strb.extWr = wrEn; end
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainCtl <= 8'h00;
      extCtl  <= 8'h00;
      extAddr <= '0;
    end else begin
      if (wrEn && regAddr == OFS_MAIN_CTL) mainCtl <= wdata;
      if (wrEn && bankSel && regAddr == OFS_EXT_CTL) extCtl <= wdata;
      if (wrEn && bankSel && regAddr == OFS_PTR_LO) extAddr[7:0] <= wdata;
      if (wrEn && bankSel && regAddr == OFS_PTR_HI) extAddr[AW-1:8] <= wdata[HW-1:0];
      if (dpAccess && burstOn) extAddr <= extAddr + 1'b1;
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dpAccess && !burstOn) |=> (extAddr == $past(extAddr))); // R6

  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (dpAccess && burstOn) |=> (extAddr == $past(extAddr) + 1'b1)); // R5

  AST_BANK0_EXT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!bankSel && wrEn && regAddr[6]) |=> ($stable(extAddr) && $stable(extCtl))); // R10

endmodule

// File: rtl/nvport_datapath.sv
module nvport_datapath
  import nvport_pkg::*;
#(
  parameter int EXT_BYTES = 2048,
  localparam int AW = $clog2(EXT_BYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  nvStrobe_t     strb,
  input  logic [AW-1:0] extAddr,
  input  logic [5:0]    userIdx,
  input  logic [7:0]    regVal,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  localparam int USER_BYTES = 64;

  logic [7:0] extMem  [EXT_BYTES];
  logic [7:0] userRam [USER_BYTES];

  always_ff @(posedge clk) begin
    if (strb.extWr)  extMem[extAddr]  <= wdata;
    if (strb.userWr) userRam[userIdx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata <= 8'h00;
    end else if (strb.rdEn) begin
      case (strb.rdSrc)
        RD_REG:  rdata <= regVal;
        RD_USER: rdata <= userRam[userIdx];
        RD_EXT:  rdata <= extMem[extAddr];
        default: rdata <= 8'h00;
      endcase
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(rdata)); // R2

endmodule

// File: rtl/nvport_top.sv
module nvport_top
  import nvport_pkg::*;
#(
  parameter int EXT_BYTES = 2048
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [6:0] regAddr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);

  localparam int AW = $clog2(EXT_BYTES);

  nvStrobe_t     strb;
  logic [AW-1:0] extAddr;
  logic [7:0]    regVal;

  nvport_ctrl #(.EXT_BYTES(EXT_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
    .wdata(wdata), .strb(strb), .extAddr(extAddr), .regVal(regVal)
  );

  nvport_datapath #(.EXT_BYTES(EXT_BYTES)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .extAddr(extAddr),
    .userIdx(regAddr[5:0]), .regVal(regVal), .wdata(wdata), .rdata(rdata)
  );

  AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.extWr && strb.userWr)); // R4

endmodule

// File: tb/sim_nvport_top.sv
module sim_nvport_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [6:0] regAddr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  nvport_top #(.EXT_BYTES(2048)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .regAddr(regAddr), .wdata(wdata), .rdata(rdata)
  );

  // vector: {tag[3:0], isRead, offset[6:0], data/expected[7:0]}
  localparam int NV = 42;
  localparam logic [19:0] VEC [NV] = '{
    {4'd3,  1'b0, 7'h0A, 8'h00}, // R3 bank 0
    {4'd3,  1'b0, 7'h45, 8'hA5},
    {4'd3,  1'b1, 7'h45, 8'hA5}, // R3 user RAM
    {4'd3,  1'b0, 7'h7F, 8'h3C},
    {4'd3,  1'b1, 7'h7F, 8'h3C}, // R3
    {4'd3,  1'b0, 7'h0A, 8'h10},
    {4'd3,  1'b1, 7'h0A, 8'h10}, // R3 bank bit
    {4'd4,  1'b0, 7'h50, 8'hFE},
    {4'd4,  1'b0, 7'h51, 8'h07},
    {4'd9,  1'b1, 7'h50, 8'hFE}, // R9
    {4'd9,  1'b1, 7'h51, 8'h07}, // R9
    {4'd6,  1'b0, 7'h53, 8'h11},
    {4'd6,  1'b1, 7'h53, 8'h11}, // R6
    {4'd6,  1'b1, 7'h50, 8'hFE}, // R6 pointer held
    {4'd4,  1'b0, 7'h4A, 8'h20},
    {4'd4,  1'b1, 7'h4A, 8'h20}, // R4 burst ctl
    {4'd5,  1'b0, 7'h53, 8'h22},
    {4'd7,  1'b0, 7'h53, 8'h33},
    {4'd7,  1'b1, 7'h50, 8'h00}, // R7 wrap
    {4'd7,  1'b1, 7'h51, 8'h00}, // R7
    {4'd5,  1'b0, 7'h50, 8'hFE},
    {4'd5,  1'b0, 7'h51, 8'h07},
    {4'd5,  1'b1, 7'h53, 8'h22}, // R5 burst read
    {4'd5,  1'b1, 7'h53, 8'h33}, // R5
    {4'd5,  1'b1, 7'h50, 8'h00}, // R5 stepped past end
    {4'd8,  1'b0, 7'h51, 8'hFF},
    {4'd8,  1'b1, 7'h51, 8'h07}, // R8 top bits dropped
    {4'd8,  1'b0, 7'h53, 8'h44},
    {4'd8,  1'b0, 7'h50, 8'h00},
    {4'd8,  1'b1, 7'h53, 8'h44}, // R8 same byte
    {4'd9,  1'b1, 7'h50, 8'h01}, // R9 burst step seen
    {4'd11, 1'b1, 7'h52, 8'h00}, // R11
    {4'd11, 1'b1, 7'h40, 8'h00}, // R11
    {4'd11, 1'b1, 7'h45, 8'h00}, // R11
    {4'd10, 1'b0, 7'h0A, 8'h00},
    {4'd10, 1'b1, 7'h45, 8'hA5}, // R10 user RAM intact
    {4'd10, 1'b0, 7'h50, 8'h77},
    {4'd10, 1'b1, 7'h50, 8'h77}, // R10
    {4'd10, 1'b0, 7'h4A, 8'h00},
    {4'd10, 1'b0, 7'h0A, 8'h10},
    {4'd10, 1'b1, 7'h50, 8'h01}, // R10 pointer kept
    {4'd10, 1'b1, 7'h4A, 8'h20}  // R10 burst ctl kept
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; wdata = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [6:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdata;
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdata", rdata, 8'h00);
    doRead(7'h0A, v); check("R1 main ctl", v, 8'h00);
    doWrite(7'h0A, 8'h10);
    doRead(7'h4A, v); check("R1 ext ctl", v, 8'h00);
    doRead(7'h50, v); check("R1 ptr lo", v, 8'h00);
    doRead(7'h51, v); check("R1 ptr hi", v, 8'h00);
    doRead(7'h00, v); check("R11 offset 0", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][15]) begin
        doRead(VEC[i][14:8], v);
        check($sformatf("R%0d vec%0d", VEC[i][19:16], i), v, VEC[i][7:0]);
      end else begin
        doWrite(VEC[i][14:8], VEC[i][7:0]);
      end
    end

    // R2: read data holds through idle cycles and writes
    doRead(7'h4A, v);
    check("R2 read value", v, 8'h20);
    doWrite(7'h4A, 8'h00);
    repeat (3) @(negedge clk);
    check("R2 hold", rdata, 8'h20);
    doRead(7'h4A, v);
    check("R2 new value", v, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule